// File: doc/BRIEF.md
# UART Power-Down and RX Wake-Up Controller

This block sits beside a UART core and decides when the core is powered. Dropping the UART enable takes the core down. Any transfer in flight is cut off with an abort strobe to the transmitter and/or the receiver. The TX line is held high, and the UART clocks are gated off as soon as the serial-interface select line is also high. Bringing the core back needs a strict order: the select line must be low first, and only then is a fresh rising edge of the UART enable accepted.

While the core is down, the block can wake the system from RX activity. At the moment of power-down it captures the wake, receive and receive-interrupt enables. It arms only if all of them were set, with the UART enable having been set up to that point. A falling RX edge, seen through a synchronizer on the free-running clock, then gives a one-cycle wake pulse. It also opens a start-up window of a fixed number of cycles. During that window the receive-ignore output stays high so that the receiver discards anything that arrives.

A wake interrupt is kept apart from the wake itself. It is raised only if the global interrupt enable was set when the wake happened, and only once the start-up window has closed. Register contents of the UART are untouched, because this block drives no reset into the core.

Top module: `uart_pwr_wake_ctl`

## Requirements
- R1: After reset the core is down: `tx_force_high`=1, `rx_ignore`=0, and `tx_abort`, `rx_abort`, `wake_pulse`, `wake_irq` are all 0.
- R2: `clk_gate_en` is 1 while the core is up. While the core is down or in its start-up window, it equals the inverse of `sif_sel`.
- R3: Power-up happens only on a clock edge where `uart_en` is sampled 1 after having been sampled 0 on the previous edge, with `sif_sel` sampled 0. From the next cycle, `tx_force_high`=0 and `clk_gate_en`=1. A rising `uart_en` while `sif_sel` is high is lost, and a later drop of `sif_sel` alone does not power up. After reset, `uart_en` must first be seen low.
- R4: While up, sampling `uart_en`=0 takes the core down on the next cycle, with `tx_force_high`=1.
- R5: `tx_abort` (resp. `rx_abort`) is a one-cycle pulse in the first down cycle, present exactly when `tx_busy` (resp. `rx_busy`) was sampled 1 at the power-down edge. It is 0 at all other times.
- R6: At the power-down edge the wake is armed if `wake_en`, `rx_en` and `rx_ie` are all 1. While down and armed, a falling edge on `rx_pin` gives `wake_pulse`=1 for one cycle, three cycles after `rx_pin` first reads low at an edge (two synchronizer stages). When not armed, no wake occurs.
- R7: `rx_ignore` rises in the cycle of `wake_pulse` and stays high for exactly `STARTUP_CYCLES` cycles.
- R8: `wake_irq` is a one-cycle pulse in the first cycle after `rx_ignore` falls, present only if `gie` was sampled 1 at the wake edge. It is never high during the window.
- R9: A wake consumes the arming: later RX edges do not wake until a new power-up and power-down. During the start-up window, changes on `uart_en` do not power the core up.
- R10: RX falling edges while the core is up never produce a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-speed clock (never gated) |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_en | input | 1 | UART enable; low requests power-down |
| sif_sel | input | 1 | Serial-interface select; high allows the clocks to stop while down |
| wake_en | input | 1 | RX wake-up enable |
| rx_en | input | 1 | Receiver enable |
| rx_ie | input | 1 | Receive interrupt enable |
| gie | input | 1 | Global interrupt enable |
| rx_pin | input | 1 | Asynchronous serial receive line |
| tx_busy | input | 1 | Transmitter has a frame in flight |
| rx_busy | input | 1 | Receiver has a frame in flight |
| clk_gate_en | output | 1 | Enable for the UART clock gate |
| tx_abort | output | 1 | One-cycle abort strobe to the transmitter |
| rx_abort | output | 1 | One-cycle abort strobe to the receiver |
| tx_force_high | output | 1 | Hold the TX pin at logic high |
| wake_pulse | output | 1 | One-cycle system wake request |
| wake_irq | output | 1 | One-cycle wake interrupt request |
| rx_ignore | output | 1 | Receiver must discard data (start-up window) |

## Verification
The checker assumes that every input except `rx_pin` is synchronous to `clk`. It also assumes that the enables are settled at the power-down edge, because that edge is where the arming is captured. The bench changes all inputs on the falling clock edge and keeps the enables and busy flags steady for a full cycle before it drops `uart_en`. Only `rx_pin` is treated as asynchronous, and the bench still moves it away from the sampling edge, so the expected wake latency is exact. The sweep covers all 64 combinations of the three wake enables, `gie` and the two busy flags, with a short start-up window. Each pass also toggles `uart_en` inside the window and sends a second RX edge after the wake.

// File: rtl/uwk_pkg.sv
package uwk_pkg;
  typedef enum logic [1:0] {
    PS_UP    = 2'd0,
    PS_DOWN  = 2'd1,
    PS_START = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/uwk_rx_edge.sv
// Synchronizes the asynchronous RX line on the free-running clock and
// flags a high-to-low transition of the synchronized value.
module uwk_rx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async,
  output logic rx_fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  assign sync_d[0] = rx_async;
  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    assign sync_d[s] = sync_q[s-1];
  end

  // Line idles high, so the chain resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rx_fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/uwk_startup_timer.sv
// Counts out the oscillator start-up window after a wake.
module uwk_startup_timer #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active,
  output logic done
);
  localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;

  assign done   = act_q && (cnt_q == '0);
  assign active = act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      act_d = 1'b1;
      cnt_d = LAST;
    end else if (done) begin
      act_d = 1'b0;
    end else if (act_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/uart_pwr_wake_ctl.sv
module uart_pwr_wake_ctl
  import uwk_pkg::*;
#(
  parameter int STARTUP_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uart_en,
  input  logic sif_sel,
  input  logic wake_en,
  input  logic rx_en,
  input  logic rx_ie,
  input  logic gie,
  input  logic rx_pin,
  input  logic tx_busy,
  input  logic rx_busy,
  output logic clk_gate_en,
  output logic tx_abort,
  output logic rx_abort,
  output logic tx_force_high,
  output logic wake_pulse,
  output logic wake_irq,
  output logic rx_ignore
);
  pwr_state_e state_q, state_d;
  logic uen_q;
  logic arm_q, arm_d;
  logic pend_q, pend_d;
  logic txa_q, txa_d, rxa_q, rxa_d;
  logic wake_q, wake_d, irq_q, irq_d;
  logic tmr_load, tmr_active, tmr_done;
  logic rx_fall, up_req;

  uwk_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_async (rx_pin),
    .rx_fall  (rx_fall)
  );

  uwk_startup_timer #(.CYCLES(STARTUP_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .active (tmr_active),
    .done   (tmr_done)
  );

  // Fresh rising enable with the select line already low.
  assign up_req = uart_en & ~uen_q & ~sif_sel;

  always_comb begin
    state_d  = state_q;
    arm_d    = arm_q;
    pend_d   = pend_q;
    txa_d    = 1'b0;
    rxa_d    = 1'b0;
    wake_d   = 1'b0;
    irq_d    = 1'b0;
    tmr_load = 1'b0;
    case (state_q)
      PS_UP: begin
        if (!uart_en) begin
          state_d = PS_DOWN;
          txa_d   = tx_busy;
          rxa_d   = rx_busy;
          arm_d   = wake_en & rx_en & rx_ie & uen_q;
        end
      end
      PS_DOWN: begin
        if (up_req) begin
          state_d = PS_UP;
          arm_d   = 1'b0;
        end else if (arm_q && rx_fall) begin
          state_d  = PS_START;
          arm_d    = 1'b0;
          pend_d   = gie;
          wake_d   = 1'b1;
          tmr_load = 1'b1;
        end
      end
      PS_START: begin
        if (tmr_done) begin
          state_d = PS_DOWN;
          irq_d   = pend_q;
          pend_d  = 1'b0;
        end
      end
      default: state_d = PS_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_DOWN;
      uen_q   <= 1'b1;
      arm_q   <= 1'b0;
      pend_q  <= 1'b0;
      txa_q   <= 1'b0;
      rxa_q   <= 1'b0;
      wake_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      uen_q   <= uart_en;
      arm_q   <= arm_d;
      pend_q  <= pend_d;
      txa_q   <= txa_d;
      rxa_q   <= rxa_d;
      wake_q  <= wake_d;
      irq_q   <= irq_d;
    end
  end

  assign clk_gate_en   = (state_q == PS_UP) | ~sif_sel;
  assign tx_force_high = (state_q != PS_UP);
  assign tx_abort      = txa_q;
  assign rx_abort      = rxa_q;
  assign wake_pulse    = wake_q;
  assign wake_irq      = irq_q;
  assign rx_ignore     = tmr_active;
endmodule

// File: rtl/uwk_checker.sv
module uwk_checker (
  input logic clk,
  input logic rst_n,
  input logic clk_gate_en,
  input logic tx_abort,
  input logic rx_abort,
  input logic tx_force_high,
  input logic wake_pulse,
  input logic wake_irq,
  input logic rx_ignore
);
  AST_CLK_ON_WHEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_force_high |-> clk_gate_en); // R2
  AST_TX_ABORT_AT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> tx_force_high && !$past(tx_force_high)); // R5
  AST_RX_ABORT_AT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |-> tx_force_high && !$past(tx_force_high)); // R5
  AST_WAKE_FROM_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(tx_force_high) && !$past(rx_ignore)); // R6
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R6
  AST_WAKE_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> rx_ignore); // R7
  AST_IRQ_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> !rx_ignore && $past(rx_ignore)); // R8
  AST_DOWN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ignore |-> tx_force_high); // R9
endmodule

bind uart_pwr_wake_ctl uwk_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .clk_gate_en   (clk_gate_en),
  .tx_abort      (tx_abort),
  .rx_abort      (rx_abort),
  .tx_force_high (tx_force_high),
  .wake_pulse    (wake_pulse),
  .wake_irq      (wake_irq),
  .rx_ignore     (rx_ignore)
);

// File: tb/uart_pwr_wake_ctl_tb_top.sv
`timescale 1ns/1ps
module uart_pwr_wake_ctl_tb_top;
  localparam int STARTUP = 8;

  logic clk, rst_n;
  logic uart_en, sif_sel, wake_en, rx_en, rx_ie, gie, rx_pin, tx_busy, rx_busy;
  logic clk_gate_en, tx_abort, rx_abort, tx_force_high, wake_pulse, wake_irq, rx_ignore;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  uart_pwr_wake_ctl #(.STARTUP_CYCLES(STARTUP), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .sif_sel(sif_sel),
    .wake_en(wake_en), .rx_en(rx_en), .rx_ie(rx_ie), .gie(gie),
    .rx_pin(rx_pin), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .clk_gate_en(clk_gate_en), .tx_abort(tx_abort), .rx_abort(rx_abort),
    .tx_force_high(tx_force_high), .wake_pulse(wake_pulse),
    .wake_irq(wake_irq), .rx_ignore(rx_ignore)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt;
    bit armed;
    rst_n = 0; uart_en = 0; sif_sel = 1; wake_en = 0; rx_en = 0; rx_ie = 0;
    gie = 0; rx_pin = 1; tx_busy = 0; rx_busy = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 force", tx_force_high, 1);
    chk("R1 ignore", rx_ignore, 0);
    chk("R1 pulses", {tx_abort, rx_abort, wake_pulse, wake_irq}, 0);
    chk("R2 gate down sel=1", clk_gate_en, 0);
    sif_sel = 0; #1;
    chk("R2 gate down sel=0", clk_gate_en, 1);

    // R3 wrong order: enable rises while select high
    step(); sif_sel = 1; uart_en = 1;
    step(); step(); sif_sel = 0;
    repeat (3) step();
    chk("R3 order violated stays down", tx_force_high, 1);
    uart_en = 0; step(); uart_en = 1; step();
    chk("R3 power up", tx_force_high, 0);
    chk("R3 clock on", clk_gate_en, 1);
    sif_sel = 1; #1;
    chk("R2 gate up ignores sel", clk_gate_en, 1);
    sif_sel = 0;

    // R10 edges while up
    rx_pin = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R10 no wake while up", wake_pulse, 0);
    end
    rx_pin = 1; repeat (3) step();

    for (int c = 0; c < 64; c++) begin
      wake_en = c[0]; rx_en = c[1]; rx_ie = c[2]; gie = c[3];
      tx_busy = c[4]; rx_busy = c[5];
      armed = c[0] & c[1] & c[2];
      step();
      uart_en = 0;
      step();
      chk("R4 down", tx_force_high, 1);
      chk("R5 tx abort", tx_abort, c[4]);
      chk("R5 rx abort", rx_abort, c[5]);
      tx_busy = 0; rx_busy = 0;
      step();
      chk("R5 abort single", {tx_abort, rx_abort}, 0);
      sif_sel = 1; #1;
      chk("R2 gated when down", clk_gate_en, 0);
      step(); sif_sel = 0;
      rx_pin = 0;
      step(); chk("R6 latency 1", wake_pulse, 0);
      step(); chk("R6 latency 2", wake_pulse, 0);
      step();
      chk("R6 wake", wake_pulse, armed);
      chk("R7 window opens", rx_ignore, armed);
      if (armed) begin
        cnt = 1;
        for (int i = 0; i < 40; i++) begin
          if (cnt == 2) uart_en = 1;
          if (cnt == 4) uart_en = 0;
          step();
          if (!rx_ignore) break;
          cnt++;
          chk("R9 stays down in window", tx_force_high, 1);
          chk("R8 no irq in window", wake_irq, 0);
        end
        chk("R7 window length", cnt, STARTUP);
        chk("R8 irq", wake_irq, c[3]);
        step();
        chk("R8 irq single", wake_irq, 0);
        rx_pin = 1; repeat (3) step();
        rx_pin = 0;
        for (int i = 0; i < 5; i++) begin
          step();
          chk("R9 arming consumed", wake_pulse, 0);
        end
      end else begin
        for (int i = 0; i < 4; i++) begin
          step();
          chk("R6 unarmed no wake", wake_pulse | rx_ignore, 0);
        end
      end
      rx_pin = 1; repeat (3) step();
      uart_en = 1;
      step();
      chk("R3 power up again", tx_force_high, 0);
    end
    finish_run();
  end
endmodule